// File: doc/BRIEF.md
# Snapshot Real-Time Counter with Alarm

This block keeps a wide free-running count on the slow real-time clock. Software does not read the live count. It writes a one-cycle update request, and the block copies the count into a pair of read words: a 32-bit low word and a 16-bit high word. A valid flag drops when the request is taken and rises one cycle later, once the copy is in place. Software polls that flag, or waits for the time-valid interrupt, and then reads the two words as one consistent value.

A 48-bit alarm value is held in two parts. A low word has its own write strobe. A high field shares a write strobe with an alarm-enable bit. When the alarm is enabled and the count reaches the alarm value exactly, the main-timer interrupt is raised. Each of the two interrupt sources has four parts: a sticky raw bit, an enable bit, a status bit equal to raw AND enable, and a write-one clear strobe. A single interrupt line is the OR of the status bits.

Top module: `rtc_snapshot_timer`

## Requirements
- R1: After reset, the snapshot words, valid flag, alarm words, alarm enable, and all raw, enable and status bits read zero, and the count restarts from zero.
- R2: The count increases by exactly one on every clock edge out of reset, so two snapshots taken N edges apart differ by N.
- R3: An update request sampled at a clock edge copies the count value present at that edge into `snap_lo` (bits 31:0) and `snap_hi` (bits 47:32). The snapshot words do not change at any other edge.
- R4: `snap_valid` clears at the edge that takes an update request and sets at the following edge, unless that edge takes another request. Once set, it stays set until the next request.
- R5: `alarm_lo_we` loads the low 32 alarm bits. `alarm_hi_we` loads the high 16 alarm bits and the alarm enable together. All three read back unchanged. A new value is first compared one edge after it is written.
- R6: Interrupt source 1 (alarm) raw bit sets at the edge where the alarm is enabled and all 48 count bits equal the alarm value. It does not set while disabled or while the high field differs.
- R7: Interrupt source 0 (time-valid) raw bit sets at the same edge at which `snap_valid` sets.
- R8: A raw bit stays set until a one is written to its bit of `irq_clr`. If a set event and a clear arrive at the same edge, the set wins.
- R9: `irq_ena` is loaded by `irq_ena_we`. `irq_stat` equals `irq_raw` AND `irq_ena`, and `irq` is high when any status bit is high. Masking a source leaves its raw bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req | input | 1 | One-cycle snapshot request (write-one) |
| alarm_lo_we | input | 1 | Load strobe for the low alarm word |
| alarm_lo_wdata | input | 32 | Low alarm word data |
| alarm_hi_we | input | 1 | Load strobe for the high alarm field and the enable |
| alarm_hi_wdata | input | 16 | High alarm field data |
| alarm_en_wdata | input | 1 | Alarm enable data |
| irq_ena_we | input | 1 | Load strobe for the interrupt enables |
| irq_ena_wdata | input | 2 | Interrupt enable data (bit 0 time-valid, bit 1 alarm) |
| irq_clr | input | 2 | Write-one clear of the raw bits |
| snap_lo | output | 32 | Snapshot, count bits 31:0 |
| snap_hi | output | 16 | Snapshot, count bits 47:32 |
| snap_valid | output | 1 | Snapshot is complete |
| alarm_lo | output | 32 | Alarm low word readback |
| alarm_hi | output | 16 | Alarm high field readback |
| alarm_en | output | 1 | Alarm enable readback |
| irq_raw | output | 2 | Raw interrupt bits |
| irq_ena | output | 2 | Interrupt enable bits |
| irq_stat | output | 2 | Masked interrupt status |
| irq | output | 1 | OR of the status bits |

## Verification
Every register result is due one edge after the stimulus that causes it, with two exceptions. The valid flag and the time-valid raw bit are due two edges after the request. The alarm raw bit is due at the edge after the one where the count equals the alarm value. Status and the interrupt line follow their raw and enable bits in the same cycle. The bench drives its strobes just after a falling edge. A reference model advances on the same rising edges, and the outputs are compared at the next falling edge, so every comparison lands in the cycle where each result is due. Alarm values are placed a known number of edges ahead of the bench's own count, so the firing edge is known in advance.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
   // interrupt source indices, fixed by the register layout software sees
   localparam int unsigned SRC_TVALID = 0;
   localparam int unsigned SRC_ALARM  = 1;
   localparam int unsigned NUM_SRC    = 2;

   typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rtc_free_counter.sv
module rtc_free_counter #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + W'(1);
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/rtc_snapshot_unit.sv
module rtc_snapshot_unit #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_req,
   input  logic [W-1:0] cnt,
   output logic [W-1:0] snap,
   output logic         valid,
   output logic         done_evt
);
   logic pend;

   // the copy finishes one edge after capture unless a new request restarts it
   assign done_evt = pend & ~upd_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap  <= '0;
         valid <= 1'b0;
         pend  <= 1'b0;
      end else if (upd_req) begin
         snap  <= cnt;
         valid <= 1'b0;
         pend  <= 1'b1;
      end else if (pend) begin
         valid <= 1'b1;
         pend  <= 1'b0;
      end
   end

   // R3
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req |=> (snap == $past(cnt)) && !valid);
   // R3
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_req |=> $stable(snap));
   // R4
   valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !upd_req) |=> valid);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int unsigned CNT_W = 48,
   parameter int unsigned LO_W  = 32,
   localparam int unsigned HI_W = CNT_W - LO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_we,
   input  logic [LO_W-1:0]  lo_d,
   input  logic             hi_we,
   input  logic [HI_W-1:0]  hi_d,
   input  logic             en_d,
   input  logic [CNT_W-1:0] cnt,
   output logic [LO_W-1:0]  alarm_lo,
   output logic [HI_W-1:0]  alarm_hi,
   output logic             alarm_en,
   output logic             hit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_lo <= '0;
         alarm_hi <= '0;
         alarm_en <= 1'b0;
      end else begin
         if (lo_we) alarm_lo <= lo_d;
         if (hi_we) begin
            alarm_hi <= hi_d;
            alarm_en <= en_d;
         end
      end
   end

   assign hit = alarm_en && (cnt == {alarm_hi, alarm_lo});

   // R5
   alarm_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we |=> (alarm_hi == $past(hi_d)) && (alarm_en == $past(en_d)));
   // R5
   alarm_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> alarm_lo == $past(lo_d));
endmodule

// File: rtl/rtc_irq_bank.sv
module rtc_irq_bank #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic         ena_we,
   input  logic [N-1:0] ena_d,
   output logic [N-1:0] raw,
   output logic [N-1:0] ena,
   output logic [N-1:0] stat,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ena <= '0;
      else if (ena_we) ena <= ena_d;
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      r <= 1'b0;
         else if (set[i]) r <= 1'b1;
         else if (clr[i]) r <= 1'b0;
      end
      assign raw[i] = r;

      // R8
      raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (r && !clr[i]) |=> r);
      // R8
      raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !r);
      // R8
      raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> r);
   end

   assign stat = raw & ena;
   assign irq  = |stat;
endmodule

// File: rtl/rtc_snapshot_timer.sv
module rtc_snapshot_timer
   import rtc_snap_pkg::*;
#(
   parameter int unsigned CNT_W = 48,
   parameter int unsigned LO_W  = 32,
   localparam int unsigned HI_W = CNT_W - LO_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_req,
   input  logic                alarm_lo_we,
   input  logic [LO_W-1:0]     alarm_lo_wdata,
   input  logic                alarm_hi_we,
   input  logic [HI_W-1:0]     alarm_hi_wdata,
   input  logic                alarm_en_wdata,
   input  logic                irq_ena_we,
   input  logic [NUM_SRC-1:0]  irq_ena_wdata,
   input  logic [NUM_SRC-1:0]  irq_clr,
   output logic [LO_W-1:0]     snap_lo,
   output logic [HI_W-1:0]     snap_hi,
   output logic                snap_valid,
   output logic [LO_W-1:0]     alarm_lo,
   output logic [HI_W-1:0]     alarm_hi,
   output logic                alarm_en,
   output logic [NUM_SRC-1:0]  irq_raw,
   output logic [NUM_SRC-1:0]  irq_ena,
   output logic [NUM_SRC-1:0]  irq_stat,
   output logic                irq
);
   if (CNT_W <= LO_W) begin : g_bad_split
      $error("CNT_W must exceed LO_W so the high field is not empty");
   end
   if (LO_W > 32) begin : g_bad_lo
      $error("low snapshot word is limited to 32 bits");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] snap;
   logic             tv_evt;
   logic             al_hit;
   src_vec_t         ev_set;

   rtc_free_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt(cnt)
   );

   rtc_snapshot_unit #(.W(CNT_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .cnt(cnt),
      .snap(snap), .valid(snap_valid), .done_evt(tv_evt)
   );

   rtc_alarm_cmp #(.CNT_W(CNT_W), .LO_W(LO_W)) u_alarm (
      .clk(clk), .rst_n(rst_n),
      .lo_we(alarm_lo_we), .lo_d(alarm_lo_wdata),
      .hi_we(alarm_hi_we), .hi_d(alarm_hi_wdata), .en_d(alarm_en_wdata),
      .cnt(cnt),
      .alarm_lo(alarm_lo), .alarm_hi(alarm_hi), .alarm_en(alarm_en),
      .hit(al_hit)
   );

   always_comb begin
      ev_set             = '0;
      ev_set[SRC_TVALID] = tv_evt;
      ev_set[SRC_ALARM]  = al_hit;
   end

   rtc_irq_bank #(.N(NUM_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(irq_clr),
      .ena_we(irq_ena_we), .ena_d(irq_ena_wdata),
      .raw(irq_raw), .ena(irq_ena), .stat(irq_stat), .irq(irq)
   );

   assign snap_lo = snap[LO_W-1:0];
   assign snap_hi = snap[CNT_W-1:LO_W];

   // R6
   alarm_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_en && cnt == {alarm_hi, alarm_lo}) |=> irq_raw[SRC_ALARM]);
   // R7
   tvalid_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snap_valid) |-> irq_raw[SRC_TVALID]);
   // R9
   irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_raw & irq_ena) != '0);
endmodule

// File: tb/sim_rtc_snapshot_timer.sv
module sim_rtc_snapshot_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_req = 1'b0;
   logic        alarm_lo_we = 1'b0;
   logic [31:0] alarm_lo_wdata = '0;
   logic        alarm_hi_we = 1'b0;
   logic [15:0] alarm_hi_wdata = '0;
   logic        alarm_en_wdata = 1'b0;
   logic        irq_ena_we = 1'b0;
   logic [1:0]  irq_ena_wdata = '0;
   logic [1:0]  irq_clr = '0;
   logic [31:0] snap_lo;
   logic [15:0] snap_hi;
   logic        snap_valid;
   logic [31:0] alarm_lo;
   logic [15:0] alarm_hi;
   logic        alarm_en;
   logic [1:0]  irq_raw, irq_ena, irq_stat;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_snapshot_timer u0 (.*);

   // reference model built from the requirements
   logic [47:0] m_cnt, m_snap, m_alarm;
   logic        m_valid, m_pend, m_al_en;
   logic [1:0]  m_raw, m_ena;

   function automatic logic [1:0] next_raw(logic [1:0] raw, logic [1:0] set,
                                           logic [1:0] clr);
      return set | (raw & ~clr);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= '0; m_snap <= '0; m_alarm <= '0; m_valid <= 1'b0;
         m_pend <= 1'b0; m_al_en <= 1'b0; m_raw <= '0; m_ena <= '0;
      end else begin
         m_cnt <= m_cnt + 48'd1;
         if (upd_req) begin
            m_snap <= m_cnt; m_valid <= 1'b0; m_pend <= 1'b1;
         end else if (m_pend) begin
            m_valid <= 1'b1; m_pend <= 1'b0;
         end
         m_raw <= next_raw(m_raw,
                           {m_al_en && (m_cnt == m_alarm), m_pend && !upd_req},
                           irq_clr);
         if (irq_ena_we) m_ena <= irq_ena_wdata;
         if (alarm_lo_we) m_alarm[31:0] <= alarm_lo_wdata;
         if (alarm_hi_we) begin
            m_alarm[47:32] <= alarm_hi_wdata; m_al_en <= alarm_en_wdata;
         end
      end
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R3 snap_lo", 64'(snap_lo), 64'(m_snap[31:0]));
      check("R3 snap_hi", 64'(snap_hi), 64'(m_snap[47:32]));
      check("R4 valid", 64'(snap_valid), 64'(m_valid));
      check("R5 alarm", 64'({alarm_en, alarm_hi, alarm_lo}), 64'({m_al_en, m_alarm}));
      check("R7 tvalid raw", 64'(irq_raw[0]), 64'(m_raw[0]));
      check("R6 alarm raw", 64'(irq_raw[1]), 64'(m_raw[1]));
      check("R9 ena", 64'(irq_ena), 64'(m_ena));
      check("R9 stat", 64'(irq_stat), 64'(m_raw & m_ena));
      check("R9 irq", 64'(irq), 64'(|(m_raw & m_ena)));
   endtask

   // one rising edge, then compare at the falling edge and drop the strobes
   task automatic cycle_once();
      @(negedge clk);
      compare_all();
      upd_req = 1'b0; alarm_lo_we = 1'b0; alarm_hi_we = 1'b0;
      irq_ena_we = 1'b0; irq_clr = '0;
   endtask

   task automatic set_alarm(logic [47:0] v, logic en);
      alarm_lo_we = 1'b1; alarm_lo_wdata = v[31:0];
      alarm_hi_we = 1'b1; alarm_hi_wdata = v[47:32]; alarm_en_wdata = en;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [47:0] s1, s2;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 snap", 64'({snap_hi, snap_lo}), 64'd0);
      check("R1 valid", 64'(snap_valid), 64'd0);
      check("R1 alarm", 64'({alarm_en, alarm_hi, alarm_lo}), 64'd0);
      check("R1 irq", 64'({irq, irq_raw, irq_ena, irq_stat}), 64'd0);
      rst_n = 1'b1;
      repeat (4) cycle_once();

      // R1 count restarts at zero: request at the first edge out of a reset
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1; upd_req = 1'b1;
      cycle_once();
      check("R1 count zero", 64'({snap_hi, snap_lo}), 64'd0);

      // R3/R4 directed snapshot and valid timing
      cycle_once();
      irq_ena_we = 1'b1; irq_ena_wdata = 2'b11;
      upd_req = 1'b1;
      cycle_once();
      s1 = {snap_hi, snap_lo};
      check("R4 valid low after request", 64'(snap_valid), 64'd0);
      repeat (37) cycle_once();
      upd_req = 1'b1;
      cycle_once();
      s2 = {snap_hi, snap_lo};
      check("R2 delta", 64'(s2 - s1), 64'd38);
      check("R4 valid low", 64'(snap_valid), 64'd0);
      cycle_once();
      check("R4 valid set", 64'(snap_valid), 64'd1);
      check("R7 tvalid raw", 64'(irq_raw[0]), 64'd1);

      // R4 back-to-back requests keep valid low
      upd_req = 1'b1; cycle_once();
      upd_req = 1'b1; cycle_once();
      check("R4 back-to-back", 64'(snap_valid), 64'd0);
      cycle_once();
      check("R4 valid after burst", 64'(snap_valid), 64'd1);

      // R8 clear, and set winning over clear
      irq_clr = 2'b01; cycle_once();
      check("R8 cleared", 64'(irq_raw[0]), 64'd0);
      upd_req = 1'b1; cycle_once();
      irq_clr = 2'b01; cycle_once();
      check("R8 set beats clear", 64'(irq_raw[0]), 64'd1);

      // R6 high field mismatch never fires
      set_alarm({16'd1, m_cnt[31:0] + 32'd5}, 1'b1);
      repeat (20) cycle_once();
      check("R6 high mismatch", 64'(irq_raw[1]), 64'd0);
      // R6 disabled alarm does not fire
      set_alarm(m_cnt + 48'd5, 1'b0);
      repeat (10) cycle_once();
      check("R6 disabled", 64'(irq_raw[1]), 64'd0);
      // R6 enabled exact match fires: value taken at edge k+1, match at edge k+6
      set_alarm(m_cnt + 48'd6, 1'b1);
      repeat (6) cycle_once();
      check("R6 not early", 64'(irq_raw[1]), 64'd0);
      cycle_once();
      check("R6 fired", 64'(irq_raw[1]), 64'd1);
      // R9 masking keeps raw
      irq_ena_we = 1'b1; irq_ena_wdata = 2'b00; cycle_once();
      check("R9 masked irq", 64'(irq), 64'd0);
      check("R9 raw kept", 64'(irq_raw[1]), 64'd1);

      // random phase checked against the model
      for (int i = 0; i < 600; i++) begin
         int sel;
         sel = int'($urandom % 8);
         case (sel)
            0, 1: upd_req = 1'b1;
            2: irq_clr = 2'($urandom);
            3: begin irq_ena_we = 1'b1; irq_ena_wdata = 2'($urandom); end
            4: set_alarm(m_cnt + 48'($urandom % 12), 1'($urandom));
            default: ;
         endcase
         cycle_once();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule